// File: doc/BRIEF.md
# Tiled Address Channel Swizzler

This block corrects the channel-select bit of a byte address so that accesses made through a plain linear path land where a tiled-surface reader looks for them. With dual-channel interleaved memory, address bit 6 picks the channel, so the channel changes every 64 bytes. A reader that walks a tiled surface also mixes higher address bits into that choice. The block rewrites bit 6 as the XOR of itself with bits 9, 10, 11 or 17. Which bits are used depends on the tiling mode of the access and on how the memory controller is set up.

The swizzle code comes from static configuration inputs. A controller-family selector chooses the rule. One family decodes a configuration word: an addressing-mode field, a channel-XOR-disable flag and an XOR-bit-select flag. Another family compares the top rank-boundary values of channel 0 and channel 1. Two further families have a fixed answer. The block reports the raw codes for X and Y tiling, and the software-visible codes with the bit-17 term removed. Each valid address request returns, one cycle later, the corrected address, the tiling mode actually applied and the software-visible code for that access. If the code is unknown, a tiling request is downgraded to linear.

Top module: `tiled_swizzle`

## Requirements
- R1: With tiling code 0 or 3 (linear), `out_addr` equals the input address, `out_tiling` is 0 and `out_code` is 0 (NONE).
- R2: With tiling code 1 (X), output bit 6 is input bit 6 XOR the bits named by `raw_x_code`. All other address bits pass unchanged. Code encoding: 0 NONE, 1 {9}, 2 {9,10}, 3 {9,11}, 4 {9,10,11}, 5 {9,17}, 6 {9,10,17}, 7 UNKNOWN (no bits).
- R3: With tiling code 2 (Y), output bit 6 is input bit 6 XOR the bits named by `raw_y_code`, using the same encoding as R2.
- R4: For family 1 (configuration word), an addressing mode `cfg_word[1:0]` of 0 (single channel) or 1 (asymmetric dual channel) gives raw codes X=0, Y=0.
- R5: For family 1, mode 2 (interleaved) with the XOR-disable flag `cfg_word[10]` set gives X=2, Y=1.
- R6: For family 1, mode 2 with `cfg_word[10]` clear gives X=4, Y=3 when the select flag `cfg_word[9]` is 0, and X=6, Y=5 when it is 1.
- R7: For family 1, a configuration word of all ones, or mode 3, gives X=7, Y=7 (UNKNOWN).
- R8: For family 2 (rank compare), unequal `rank_top_ch0` and `rank_top_ch1` give X=0, Y=0. Equal values give X=2, Y=1.
- R9: Family 0 always gives X=0, Y=0. Family 3 always gives X=2, Y=1.
- R10: The reported codes `rep_x_code`, `rep_y_code` and `out_code` map 5 to 1 and 6 to 2, and pass every other code unchanged.
- R11: A tiled request whose raw code is 7 leaves with `out_tiling` 0, `out_code` 0 and the address unchanged.
- R12: `out_valid` follows `in_valid` one cycle later. When `in_valid` is low, `out_addr`, `out_tiling` and `out_code` hold their values. Reset clears all registered outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_family | input | 2 | Controller family: 0 none, 1 configuration word, 2 rank compare, 3 fixed |
| cfg_word | input | CFG_W | Memory configuration word (family 1) |
| rank_top_ch0 | input | RANK_W | Channel 0 top rank boundary (family 2) |
| rank_top_ch1 | input | RANK_W | Channel 1 top rank boundary (family 2) |
| in_valid | input | 1 | Address request valid |
| in_addr | input | ADDR_W | Byte address |
| in_tiling | input | 2 | Tiling mode: 0 linear, 1 X, 2 Y, 3 linear |
| raw_x_code | output | 3 | Derived swizzle code for X tiling |
| raw_y_code | output | 3 | Derived swizzle code for Y tiling |
| rep_x_code | output | 3 | Software-visible X code, bit-17 term removed |
| rep_y_code | output | 3 | Software-visible Y code, bit-17 term removed |
| out_valid | output | 1 | Result valid |
| out_addr | output | ADDR_W | Swizzled address |
| out_tiling | output | 2 | Tiling mode applied after any downgrade |
| out_code | output | 3 | Software-visible code for the applied mode |

## Verification
Every configuration outcome is set up in turn: each family, each addressing mode, both flags, the all-ones word, and equal and unequal rank values. For each one, the five address bits 6, 9, 10, 11 and 17 run through all 32 combinations under all four tiling codes. This separates a wrong choice of XOR bit (for example 11 against 17), a wrong bit between the X and Y tables, and a wrong linear pass-through. Gaps in `in_valid` show whether the outputs hold when no request arrives. Random upper and lower address bits show whether any bit other than 6 is disturbed.

// File: rtl/swz_pkg.sv
package swz_pkg;
   typedef enum logic [2:0] {
      SWZ_NONE     = 3'd0,
      SWZ_9        = 3'd1,
      SWZ_9_10     = 3'd2,
      SWZ_9_11     = 3'd3,
      SWZ_9_10_11  = 3'd4,
      SWZ_9_17     = 3'd5,
      SWZ_9_10_17  = 3'd6,
      SWZ_UNKNOWN  = 3'd7
   } swz_code_t;

   typedef enum logic [1:0] {
      TILE_LINEAR = 2'd0,
      TILE_X      = 2'd1,
      TILE_Y      = 2'd2,
      TILE_ALT    = 2'd3
   } tile_mode_t;

   typedef enum logic [1:0] {
      FAM_PLAIN  = 2'd0,
      FAM_CFGW   = 2'd1,
      FAM_RANK   = 2'd2,
      FAM_FIXED  = 2'd3
   } ctrl_family_t;

   typedef enum logic [1:0] {
      AMODE_SINGLE = 2'd0,
      AMODE_ASYM   = 2'd1,
      AMODE_ILV    = 2'd2,
      AMODE_RSVD   = 2'd3
   } addr_mode_t;

   // Highest address bit that any swizzle term touches.
   localparam int SWZ_TOP_BIT = 17;
   localparam int SWZ_CHAN_BIT = 6;
endpackage

// File: rtl/swz_cfg_decode.sv
module swz_cfg_decode
   import swz_pkg::*;
#(
   parameter int CFG_W     = 32,
   parameter int RANK_W    = 16,
   parameter int MODE_LSB  = 0,
   parameter int XSEL_BIT  = 9,
   parameter int XDIS_BIT  = 10
) (
   input  logic [1:0]        family,
   input  logic [CFG_W-1:0]  cfg_word,
   input  logic [RANK_W-1:0] rank0,
   input  logic [RANK_W-1:0] rank1,
   output swz_code_t         code_x,
   output swz_code_t         code_y
);
   localparam int MODE_MSB = MODE_LSB + 1;

   initial begin : p_param_chk
      if (MODE_MSB >= CFG_W || XSEL_BIT >= CFG_W || XDIS_BIT >= CFG_W)
         $fatal(1, "swz_cfg_decode: field outside configuration word");
      if (XSEL_BIT == XDIS_BIT)
         $fatal(1, "swz_cfg_decode: flag positions collide");
   end

   addr_mode_t amode;
   logic       word_dead;
   logic       xor_off;
   logic       hi_sel;
   swz_code_t  cw_x, cw_y;
   swz_code_t  rk_x, rk_y;

   assign amode     = addr_mode_t'(cfg_word[MODE_MSB:MODE_LSB]);
   assign word_dead = &cfg_word;
   assign xor_off   = cfg_word[XDIS_BIT];
   assign hi_sel    = cfg_word[XSEL_BIT];

   // Configuration-word family
   always_comb begin
      cw_x = SWZ_UNKNOWN;
      cw_y = SWZ_UNKNOWN;
      unique case (amode)
         AMODE_SINGLE, AMODE_ASYM: begin
            cw_x = SWZ_NONE;
            cw_y = SWZ_NONE;
         end
         AMODE_ILV: begin
            if (xor_off) begin
               cw_x = SWZ_9_10;
               cw_y = SWZ_9;
            end else if (!hi_sel) begin
               cw_x = SWZ_9_10_11;
               cw_y = SWZ_9_11;
            end else begin
               cw_x = SWZ_9_10_17;
               cw_y = SWZ_9_17;
            end
         end
         default: begin
            cw_x = SWZ_UNKNOWN;
            cw_y = SWZ_UNKNOWN;
         end
      endcase
      if (word_dead) begin
         cw_x = SWZ_UNKNOWN;
         cw_y = SWZ_UNKNOWN;
      end
   end

   // Rank-compare family
   always_comb begin
      if (rank0 == rank1) begin
         rk_x = SWZ_9_10;
         rk_y = SWZ_9;
      end else begin
         rk_x = SWZ_NONE;
         rk_y = SWZ_NONE;
      end
   end

   always_comb begin
      unique case (ctrl_family_t'(family))
         FAM_PLAIN: begin
            code_x = SWZ_NONE;
            code_y = SWZ_NONE;
         end
         FAM_CFGW: begin
            code_x = cw_x;
            code_y = cw_y;
         end
         FAM_RANK: begin
            code_x = rk_x;
            code_y = rk_y;
         end
         default: begin
            code_x = SWZ_9_10;
            code_y = SWZ_9;
         end
      endcase
   end
endmodule

// File: rtl/swz_code_report.sv
module swz_code_report
   import swz_pkg::*;
#(
   parameter bit HIDE_HIGH = 1'b1
) (
   input  swz_code_t raw,
   output swz_code_t shown
);
   generate
      if (HIDE_HIGH) begin : g_hide
         always_comb begin
            unique case (raw)
               SWZ_9_17:    shown = SWZ_9;
               SWZ_9_10_17: shown = SWZ_9_10;
               default:     shown = raw;
            endcase
         end
      end else begin : g_pass
         assign shown = raw;
      end
   endgenerate
endmodule

// File: rtl/swz_addr_xform.sv
module swz_addr_xform
   import swz_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [ADDR_W-1:0] in_addr,
   input  tile_mode_t        req_mode,
   input  swz_code_t         code_x,
   input  swz_code_t         code_y,
   input  swz_code_t         shown_x,
   input  swz_code_t         shown_y,
   output logic              out_valid,
   output logic [ADDR_W-1:0] out_addr,
   output tile_mode_t        out_mode,
   output swz_code_t         out_code
);
   initial begin : p_param_chk
      if (ADDR_W <= SWZ_TOP_BIT)
         $fatal(1, "swz_addr_xform: address too narrow for swizzle terms");
   end

   function automatic logic [ADDR_W-1:0] term_mask(input swz_code_t c);
      logic [ADDR_W-1:0] m;
      m = '0;
      if (c != SWZ_NONE && c != SWZ_UNKNOWN) m[9] = 1'b1;
      if (c == SWZ_9_10 || c == SWZ_9_10_11 || c == SWZ_9_10_17) m[10] = 1'b1;
      if (c == SWZ_9_11 || c == SWZ_9_10_11) m[11] = 1'b1;
      if (c == SWZ_9_17 || c == SWZ_9_10_17) m[SWZ_TOP_BIT] = 1'b1;
      return m;
   endfunction

   swz_code_t         sel_raw, sel_shown;
   tile_mode_t        eff_mode;
   swz_code_t         eff_raw, eff_shown;
   logic [ADDR_W-1:0] mask;
   logic              flip;
   logic [ADDR_W-1:0] nxt_addr;

   always_comb begin
      unique case (req_mode)
         TILE_X: begin
            sel_raw   = code_x;
            sel_shown = shown_x;
         end
         TILE_Y: begin
            sel_raw   = code_y;
            sel_shown = shown_y;
         end
         default: begin
            sel_raw   = SWZ_NONE;
            sel_shown = SWZ_NONE;
         end
      endcase
   end

   always_comb begin
      if (sel_raw == SWZ_UNKNOWN || req_mode == TILE_ALT || req_mode == TILE_LINEAR) begin
         eff_mode  = TILE_LINEAR;
         eff_raw   = SWZ_NONE;
         eff_shown = SWZ_NONE;
      end else begin
         eff_mode  = req_mode;
         eff_raw   = sel_raw;
         eff_shown = sel_shown;
      end
   end

   assign mask = term_mask(eff_raw);
   assign flip = ^(in_addr & mask);

   always_comb begin
      nxt_addr = in_addr;
      nxt_addr[SWZ_CHAN_BIT] = in_addr[SWZ_CHAN_BIT] ^ flip;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_addr  <= '0;
         out_mode  <= TILE_LINEAR;
         out_code  <= SWZ_NONE;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_addr <= nxt_addr;
            out_mode <= eff_mode;
            out_code <= eff_shown;
         end
      end
   end
endmodule

// File: rtl/tiled_swizzle.sv
module tiled_swizzle
   import swz_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int CFG_W     = 32,
   parameter int RANK_W    = 16,
   parameter int MODE_LSB  = 0,
   parameter int XSEL_BIT  = 9,
   parameter int XDIS_BIT  = 10,
   parameter bit HIDE_HIGH = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        cfg_family,
   input  logic [CFG_W-1:0]  cfg_word,
   input  logic [RANK_W-1:0] rank_top_ch0,
   input  logic [RANK_W-1:0] rank_top_ch1,
   input  logic              in_valid,
   input  logic [ADDR_W-1:0] in_addr,
   input  logic [1:0]        in_tiling,
   output logic [2:0]        raw_x_code,
   output logic [2:0]        raw_y_code,
   output logic [2:0]        rep_x_code,
   output logic [2:0]        rep_y_code,
   output logic              out_valid,
   output logic [ADDR_W-1:0] out_addr,
   output logic [1:0]        out_tiling,
   output logic [2:0]        out_code
);
   localparam int N_AXES = 2;

   swz_code_t  raw_c [N_AXES];
   swz_code_t  shown_c [N_AXES];
   tile_mode_t o_mode;
   swz_code_t  o_code;

   swz_cfg_decode #(
      .CFG_W(CFG_W), .RANK_W(RANK_W), .MODE_LSB(MODE_LSB),
      .XSEL_BIT(XSEL_BIT), .XDIS_BIT(XDIS_BIT)
   ) u_decode (
      .family  (cfg_family),
      .cfg_word(cfg_word),
      .rank0   (rank_top_ch0),
      .rank1   (rank_top_ch1),
      .code_x  (raw_c[0]),
      .code_y  (raw_c[1])
   );

   for (genvar g = 0; g < N_AXES; g++) begin : g_report
      swz_code_report #(.HIDE_HIGH(HIDE_HIGH)) u_rep (
         .raw  (raw_c[g]),
         .shown(shown_c[g])
      );
   end

   swz_addr_xform #(.ADDR_W(ADDR_W)) u_xform (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .in_addr  (in_addr),
      .req_mode (tile_mode_t'(in_tiling)),
      .code_x   (raw_c[0]),
      .code_y   (raw_c[1]),
      .shown_x  (shown_c[0]),
      .shown_y  (shown_c[1]),
      .out_valid(out_valid),
      .out_addr (out_addr),
      .out_mode (o_mode),
      .out_code (o_code)
   );

   assign raw_x_code = raw_c[0];
   assign raw_y_code = raw_c[1];
   assign rep_x_code = shown_c[0];
   assign rep_y_code = shown_c[1];
   assign out_tiling = o_mode;
   assign out_code   = o_code;
endmodule

// File: rtl/swz_checker.sv
module swz_checker #(
   parameter int ADDR_W = 32,
   parameter int CFG_W  = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        cfg_family,
   input logic [CFG_W-1:0]  cfg_word,
   input logic              in_valid,
   input logic [ADDR_W-1:0] in_addr,
   input logic [1:0]        in_tiling,
   input logic [2:0]        raw_x_code,
   input logic [2:0]        rep_x_code,
   input logic [2:0]        rep_y_code,
   input logic              out_valid,
   input logic [ADDR_W-1:0] out_addr,
   input logic [1:0]        out_tiling,
   input logic [2:0]        out_code
);
   AST_LINEAR_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (in_tiling == 2'd0 || in_tiling == 2'd3)) |=>
      (out_addr == $past(in_addr) && out_tiling == 2'd0 && out_code == 3'd0)); // R1

   AST_ONLY_BIT6: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (out_addr[ADDR_W-1:7] == $past(in_addr[ADDR_W-1:7]) &&
                    out_addr[5:0] == $past(in_addr[5:0]))); // R2

   AST_DEAD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_family == 2'd1 && &cfg_word) |-> raw_x_code == 3'd7); // R7

   AST_HIDE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (rep_x_code != 3'd5 && rep_x_code != 3'd6 &&
       rep_y_code != 3'd5 && rep_y_code != 3'd6 &&
       out_code != 3'd5 && out_code != 3'd6)); // R10

   AST_UNKNOWN_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_tiling == 2'd1 && raw_x_code == 3'd7) |=>
      (out_tiling == 2'd0 && out_code == 3'd0 && out_addr == $past(in_addr))); // R11

   AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid); // R12

   AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && $stable(out_addr) && $stable(out_tiling))); // R12
endmodule

bind tiled_swizzle swz_checker #(.ADDR_W(ADDR_W), .CFG_W(CFG_W)) u_swz_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_family(cfg_family),
   .cfg_word  (cfg_word),
   .in_valid  (in_valid),
   .in_addr   (in_addr),
   .in_tiling (in_tiling),
   .raw_x_code(raw_x_code),
   .rep_x_code(rep_x_code),
   .rep_y_code(rep_y_code),
   .out_valid (out_valid),
   .out_addr  (out_addr),
   .out_tiling(out_tiling),
   .out_code  (out_code)
);

// File: tb/tb_tiled_swizzle.sv
module tb_tiled_swizzle;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 32;
   localparam int CW = 32;
   localparam int RW = 16;
   localparam int WATCHDOG = 50000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    cfg_family = '0;
   logic [CW-1:0] cfg_word = '0;
   logic [RW-1:0] rank_top_ch0 = '0;
   logic [RW-1:0] rank_top_ch1 = '0;
   logic          in_valid = 1'b0;
   logic [AW-1:0] in_addr = '0;
   logic [1:0]    in_tiling = '0;
   logic [2:0]    raw_x_code, raw_y_code, rep_x_code, rep_y_code, out_code;
   logic          out_valid;
   logic [AW-1:0] out_addr;
   logic [1:0]    out_tiling;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   // reference registered state
   bit          m_valid = 0;
   logic [AW-1:0] m_addr = '0;
   int          m_tiling = 0;
   int          m_code = 0;
   string       m_tag = "R12";

   tiled_swizzle dut (
      .clk(clk), .rst_n(rst_n), .cfg_family(cfg_family), .cfg_word(cfg_word),
      .rank_top_ch0(rank_top_ch0), .rank_top_ch1(rank_top_ch1),
      .in_valid(in_valid), .in_addr(in_addr), .in_tiling(in_tiling),
      .raw_x_code(raw_x_code), .raw_y_code(raw_y_code),
      .rep_x_code(rep_x_code), .rep_y_code(rep_y_code),
      .out_valid(out_valid), .out_addr(out_addr),
      .out_tiling(out_tiling), .out_code(out_code)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input string tag, input string what, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // Reference decode of the configuration: returns x, y codes and the requirement tag.
   task automatic model_cfg(output int x, output int y, output string tag);
      int mode;
      mode = int'(cfg_word[1:0]);
      case (cfg_family)
         2'd0: begin x = 0; y = 0; tag = "R9"; end
         2'd3: begin x = 2; y = 1; tag = "R9"; end
         2'd2: begin
            tag = "R8";
            if (rank_top_ch0 == rank_top_ch1) begin x = 2; y = 1; end
            else begin x = 0; y = 0; end
         end
         default: begin
            if (cfg_word == '1) begin x = 7; y = 7; tag = "R7"; end
            else if (mode == 3) begin x = 7; y = 7; tag = "R7"; end
            else if (mode < 2) begin x = 0; y = 0; tag = "R4"; end
            else if (cfg_word[10]) begin x = 2; y = 1; tag = "R5"; end
            else if (!cfg_word[9]) begin x = 4; y = 3; tag = "R6"; end
            else begin x = 6; y = 5; tag = "R6"; end
         end
      endcase
   endtask

   function automatic int hide(input int c);
      if (c == 5) return 1;
      if (c == 6) return 2;
      return c;
   endfunction

   function automatic bit xor_term(input int c, input logic [AW-1:0] a);
      case (c)
         1: return a[9];
         2: return a[9] ^ a[10];
         3: return a[9] ^ a[11];
         4: return a[9] ^ a[10] ^ a[11];
         5: return a[9] ^ a[17];
         6: return a[9] ^ a[10] ^ a[17];
         default: return 1'b0;
      endcase
   endfunction

   task automatic step(input bit v, input logic [AW-1:0] a, input int til);
      int cx, cy, code;
      string ctag;
      in_valid  = v;
      in_addr   = a;
      in_tiling = til[1:0];
      model_cfg(cx, cy, ctag);
      if (v) begin
         m_addr = a;
         if (til == 1 || til == 2) begin
            code = (til == 1) ? cx : cy;
            if (code == 7) begin
               m_tiling = 0; m_code = 0; m_tag = "R11";
            end else begin
               m_tiling = til;
               m_code = hide(code);
               m_addr[6] = a[6] ^ xor_term(code, a);
               m_tag = (til == 1) ? "R2" : "R3";
            end
         end else begin
            m_tiling = 0; m_code = 0; m_tag = "R1";
         end
      end
      m_valid = v;
      #1;
      check(ctag, "raw_x_code", raw_x_code, cx);
      check(ctag, "raw_y_code", raw_y_code, cy);
      check("R10", "rep_x_code", rep_x_code, hide(cx));
      check("R10", "rep_y_code", rep_y_code, hide(cy));
      @(negedge clk);
      check("R12", "out_valid", out_valid, m_valid);
      check(v ? m_tag : "R12", "out_addr", out_addr, m_addr);
      check(v ? m_tag : "R12", "out_tiling", out_tiling, m_tiling);
      check(v ? ((m_tag == "R1" || m_tag == "R11") ? m_tag : "R10") : "R12",
            "out_code", out_code, m_code);
   endtask

   task automatic sweep();
      for (int til = 0; til < 4; til++) begin
         for (int p = 0; p < 32; p++) begin
            logic [AW-1:0] a;
            a = $urandom;
            a[6] = p[0]; a[9] = p[1]; a[10] = p[2]; a[11] = p[3]; a[17] = p[4];
            step((p % 7) != 3, a, til);
         end
      end
   endtask

   initial begin : watchdog
      repeat (WATCHDOG) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : main
      repeat (3) @(negedge clk);
      check("R12", "reset out_valid", out_valid, 0);
      check("R12", "reset out_addr", out_addr, 0);
      check("R12", "reset out_tiling", out_tiling, 0);
      check("R12", "reset out_code", out_code, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // family 1: configuration word
      cfg_family = 2'd1;
      cfg_word = 32'h0000_0000; sweep();             // R4 single
      cfg_word = 32'h0000_0601; sweep();             // R4 asymmetric
      cfg_word = 32'h0000_0402; sweep();             // R5 xor disabled
      cfg_word = 32'h0000_0002; sweep();             // R6 bit 11
      cfg_word = 32'h0000_0202; sweep();             // R6 bit 17
      cfg_word = 32'hFFFF_FFFF; sweep();             // R7 dead word
      cfg_word = 32'h0000_0003; sweep();             // R7 reserved mode
      // family 2: rank compare
      cfg_family = 2'd2;
      rank_top_ch0 = 16'h0040; rank_top_ch1 = 16'h0040; sweep(); // R8 equal
      rank_top_ch1 = 16'h0080; sweep();                          // R8 unequal
      // fixed families
      cfg_family = 2'd0; cfg_word = 32'h0000_0202; sweep();      // R9
      cfg_family = 2'd3; sweep();                                // R9

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule